// File: doc/BRIEF.md
# Logical Device Resource Register Bank

This block holds the configuration state of one logical device on a legacy expansion card. System software reaches it through an 8-bit configuration index space. The bank stores an activate control, a range-check control, a set of 16-bit I/O base addresses, interrupt selections and DMA channel selections. All of these can be read back through the same index space.

While the device is switched off and range checking is enabled, the bank watches host I/O reads. When a read lands inside one of the device's programmed I/O windows, the bank answers with a fixed test pattern. Configuration software uses this answer to find out whether a candidate I/O assignment collides with another card. A card-level controller gates all register writes with a configuration-state enable. It can also return the whole bank to its power-up values with a single pulse.

Top module: `ldev_cfg_bank`

## Requirements
- R1: After `rst`, or one edge after a `dflt_pulse`, every register reads its power-up value. DMA entries read 0x04, every other index reads 0x00, and `active` is 0. A `dflt_pulse` wins over a write in the same cycle. `dflt_pulse` does not touch `rdata`.
- R2: A `wr_stb` while `cfg_en` is 0 changes nothing.
- R3: Index 0x30 bit 0 is the activate bit. It drives `active` from the edge that writes it. Bits [7:1] of index 0x30 read 0.
- R4: Index 0x31 bit 1 enables the range check and bit 0 selects the probe pattern. Bits [7:2] read 0. A write of 1 to index 0x30 bit 0 also clears index 0x31 bit 1.
- R5: I/O window n (n = 0..7) has its high base byte at index 0x60+2n and its low base byte at index 0x61+2n. Both bytes are fully readable and writable.
- R6: Interrupt entry n (n = 0..1) keeps a level in bits [3:0] at index 0x70+2n. It keeps polarity in bit 1 and type in bit 0 at index 0x71+2n. The unused bits read 0.
- R7: DMA entry n (n = 0..1) at index 0x74+n keeps a channel number in bits [2:0]. The value 4 means no channel. Bits [7:3] read 0.
- R8: Any index not listed in R3 to R7 reads 0x00, and writes to it have no effect.
- R9: `rdata` loads the addressed value at an edge where `rd_stb` is 1 and holds it otherwise. A write in the same cycle as a read does not show up in that read.
- R10: The bank answers a probe when `host_rd` is 1, range check is enabled and the device is inactive, and `host_addr` lies in [base, base+IO_SPAN) of some nonzero base. At the next edge `host_hit` becomes 1 and `host_data` becomes 0x55 if index 0x31 bit 0 is 1, or 0xAA if it is 0.
- R11: In every other case `host_hit` is 0 and `host_data` is 0x00 after the edge. This covers a disabled check, an active device, a zero base and an address outside every window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Card is in configuration state; enables writes |
| idx | input | 8 | Configuration register index |
| wdata | input | 8 | Configuration write data |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| dflt_pulse | input | 1 | Return all bank registers to power-up values |
| host_rd | input | 1 | Host I/O read in progress |
| host_addr | input | 16 | Host I/O read address |
| rdata | output | 8 | Registered configuration read data |
| host_hit | output | 1 | Registered: bank is answering a range-check probe |
| host_data | output | 8 | Registered probe answer pattern |
| active | output | 1 | Logical device is active |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. A read strobe updates `rdata` at the edge that samples it. A write changes `active` and the stored registers at that edge. A probe read shows on `host_hit` and `host_data` at the same edge. The bench drives stimulus just after an edge and advances its behavioural model at the next edge, using the register state from before that edge. It compares all four outputs one time unit later, so same-cycle write/read and activate/probe ordering follow R9 and R10.

// File: rtl/ldev_pkg.sv
package ldev_pkg;
  localparam logic [7:0] IDX_ACT  = 8'h30;
  localparam logic [7:0] IDX_RCHK = 8'h31;
  localparam logic [7:0] IDX_IO   = 8'h60;
  localparam logic [7:0] IDX_IRQ  = 8'h70;
  localparam logic [7:0] IDX_DMA  = 8'h74;
  localparam logic [2:0] DMA_NONE = 3'd4;
  localparam logic [7:0] PAT_SET  = 8'h55;
  localparam logic [7:0] PAT_CLR  = 8'hAA;
endpackage

// File: rtl/ldev_regs.sv
module ldev_regs
  import ldev_pkg::*;
#(
  parameter int NUM_IO  = 8,
  parameter int NUM_IRQ = 2,
  parameter int NUM_DMA = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_en,
  input  logic [7:0]            idx,
  input  logic [7:0]            wdata,
  input  logic                  wr_stb,
  input  logic                  rd_stb,
  input  logic                  dflt,
  output logic [7:0]            rdata,
  output logic                  act,
  output logic                  rc_en,
  output logic                  rc_pat,
  output logic [NUM_IO*16-1:0]  io_base
);
  logic [7:0] io_hi   [NUM_IO];
  logic [7:0] io_lo   [NUM_IO];
  logic [3:0] irq_lvl [NUM_IRQ];
  logic [1:0] irq_ctl [NUM_IRQ];
  logic [2:0] dma_ch  [NUM_DMA];
  logic [7:0] rd_mux;
  logic       wr_go;

  assign wr_go = wr_stb && cfg_en;

  always_ff @(posedge clk) begin
    if (rst || dflt) begin
      act    <= 1'b0;
      rc_en  <= 1'b0;
      rc_pat <= 1'b0;
      for (int i = 0; i < NUM_IO; i++) begin
        io_hi[i] <= '0;
        io_lo[i] <= '0;
      end
      for (int i = 0; i < NUM_IRQ; i++) begin
        irq_lvl[i] <= '0;
        irq_ctl[i] <= '0;
      end
      for (int i = 0; i < NUM_DMA; i++) dma_ch[i] <= DMA_NONE;
    end else if (wr_go) begin
      if (idx == IDX_ACT) begin
        act <= wdata[0];
        if (wdata[0]) rc_en <= 1'b0;
      end
      if (idx == IDX_RCHK) begin
        rc_en  <= wdata[1];
        rc_pat <= wdata[0];
      end
      for (int i = 0; i < NUM_IO; i++) begin
        if (idx == IDX_IO + 8'(2*i))     io_hi[i] <= wdata;
        if (idx == IDX_IO + 8'(2*i + 1)) io_lo[i] <= wdata;
      end
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (idx == IDX_IRQ + 8'(2*i))     irq_lvl[i] <= wdata[3:0];
        if (idx == IDX_IRQ + 8'(2*i + 1)) irq_ctl[i] <= wdata[1:0];
      end
      for (int i = 0; i < NUM_DMA; i++)
        if (idx == IDX_DMA + 8'(i)) dma_ch[i] <= wdata[2:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (idx == IDX_ACT)  rd_mux = {7'b0, act};
    if (idx == IDX_RCHK) rd_mux = {6'b0, rc_en, rc_pat};
    for (int i = 0; i < NUM_IO; i++) begin
      if (idx == IDX_IO + 8'(2*i))     rd_mux = io_hi[i];
      if (idx == IDX_IO + 8'(2*i + 1)) rd_mux = io_lo[i];
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (idx == IDX_IRQ + 8'(2*i))     rd_mux = {4'b0, irq_lvl[i]};
      if (idx == IDX_IRQ + 8'(2*i + 1)) rd_mux = {6'b0, irq_ctl[i]};
    end
    for (int i = 0; i < NUM_DMA; i++)
      if (idx == IDX_DMA + 8'(i)) rd_mux = {5'b0, dma_ch[i]};
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_stb) rdata <= rd_mux;
  end

  for (genvar g = 0; g < NUM_IO; g++) begin : g_base
    assign io_base[g*16 +: 16] = {io_hi[g], io_lo[g]};
  end

  // R2: writes outside configuration state leave the controls untouched
  a_r2_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !cfg_en && !dflt) |=> ($stable(act) && $stable(rc_en) && $stable(rc_pat)));

  // R4: activation clears the range-check enable
  a_r4_act_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_go && !dflt && idx == IDX_ACT && wdata[0]) |=> !rc_en);

  // R1: defaults pulse drops activation and range check
  a_r1_defaults: assert property (@(posedge clk) disable iff (rst)
    dflt |=> (!act && !rc_en && !rc_pat));

  // R3: reserved bits of the activate register read zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && idx == IDX_ACT) |=> (rdata[7:1] == 7'd0));
endmodule

// File: rtl/ldev_range_probe.sv
module ldev_range_probe
  import ldev_pkg::*;
#(
  parameter int NUM_IO  = 8,
  parameter int IO_SPAN = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_rd,
  input  logic [15:0]          host_addr,
  input  logic [NUM_IO*16-1:0] io_base,
  input  logic                 armed,
  input  logic                 pat,
  output logic                 host_hit,
  output logic [7:0]           host_data
);
  localparam logic [16:0] SPAN17 = 17'(IO_SPAN);

  logic [NUM_IO-1:0] win_hit;

  for (genvar g = 0; g < NUM_IO; g++) begin : g_win
    logic [15:0] base;
    logic [16:0] diff;
    assign base       = io_base[g*16 +: 16];
    assign diff       = {1'b0, host_addr} - {1'b0, base};
    assign win_hit[g] = (base != 16'd0) && (diff < SPAN17);
  end

  logic take;
  assign take = host_rd && armed && (|win_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      host_hit  <= 1'b0;
      host_data <= '0;
    end else begin
      host_hit  <= take;
      host_data <= take ? (pat ? PAT_SET : PAT_CLR) : 8'h00;
    end
  end

  // R11: no answer without a host read
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> (!host_hit && host_data == 8'h00));
endmodule

// File: rtl/ldev_cfg_bank.sv
module ldev_cfg_bank #(
  parameter int NUM_IO  = 8,
  parameter int NUM_IRQ = 2,
  parameter int NUM_DMA = 2,
  parameter int IO_SPAN = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  input  logic        wr_stb,
  input  logic        rd_stb,
  input  logic        dflt_pulse,
  input  logic        host_rd,
  input  logic [15:0] host_addr,
  output logic [7:0]  rdata,
  output logic        host_hit,
  output logic [7:0]  host_data,
  output logic        active
);
  logic                 rc_en;
  logic                 rc_pat;
  logic [NUM_IO*16-1:0] io_base;

  ldev_regs #(.NUM_IO(NUM_IO), .NUM_IRQ(NUM_IRQ), .NUM_DMA(NUM_DMA)) u_regs (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .idx(idx), .wdata(wdata),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .dflt(dflt_pulse), .rdata(rdata),
    .act(active), .rc_en(rc_en), .rc_pat(rc_pat), .io_base(io_base)
  );

  ldev_range_probe #(.NUM_IO(NUM_IO), .IO_SPAN(IO_SPAN)) u_probe (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_addr(host_addr),
    .io_base(io_base), .armed(rc_en && !active), .pat(rc_pat),
    .host_hit(host_hit), .host_data(host_data)
  );

  // R10: a probe answer only follows a cycle in which the device was inactive
  a_r10_inactive_only: assert property (@(posedge clk) disable iff (rst)
    host_hit |-> !$past(active));
endmodule

// File: tb/ldev_cfg_bank_test.sv
module ldev_cfg_bank_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_en = 0;
  logic [7:0]  idx = 0;
  logic [7:0]  wdata = 0;
  logic        wr_stb = 0;
  logic        rd_stb = 0;
  logic        dflt_pulse = 0;
  logic        host_rd = 0;
  logic [15:0] host_addr = 0;
  logic [7:0]  rdata;
  logic        host_hit;
  logic [7:0]  host_data;
  logic        active;

  always #2 clk = ~clk;

  ldev_cfg_bank uut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .idx(idx), .wdata(wdata),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .dflt_pulse(dflt_pulse),
    .host_rd(host_rd), .host_addr(host_addr), .rdata(rdata),
    .host_hit(host_hit), .host_data(host_data), .active(active)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  string phase = "R1";

  int regb [256];
  int exp_rdata = 0;
  int exp_hit   = 0;
  int exp_hdata = 0;

  function automatic int rmask(int i);
    if (i == 'h30) return 'h01;
    if (i == 'h31) return 'h03;
    if (i >= 'h60 && i <= 'h6F) return 'hFF;
    if (i == 'h70 || i == 'h72) return 'h0F;
    if (i == 'h71 || i == 'h73) return 'h03;
    if (i == 'h74 || i == 'h75) return 'h07;
    return 0;
  endfunction

  task automatic model_defaults();
    for (int i = 0; i < 256; i++) regb[i] = 0;
    regb['h74] = 4;
    regb['h75] = 4;
  endtask

  task automatic model_edge();
    int hit;
    if (rst) begin
      model_defaults();
      exp_rdata = 0; exp_hit = 0; exp_hdata = 0;
      return;
    end
    hit = 0;
    if (host_rd && regb['h31][1] && !regb['h30][0])
      for (int n = 0; n < 8; n++) begin
        int base;
        base = regb['h60 + 2*n] * 256 + regb['h61 + 2*n];
        if (base != 0 && int'(host_addr) >= base && int'(host_addr) - base < 8) hit = 1;
      end
    exp_hit   = hit;
    exp_hdata = hit ? (regb['h31][0] ? 'h55 : 'hAA) : 0;
    if (rd_stb) exp_rdata = regb[idx];
    if (dflt_pulse) model_defaults();
    else if (wr_stb && cfg_en) begin
      regb[idx] = wdata & rmask(idx);
      if (idx == 8'h30 && wdata[0]) regb['h31] = regb['h31] & 'h01;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    #1;
    vectors++;
    if (int'(rdata) != exp_rdata) begin
      fails++; $display("FAIL %s rdata got %02h exp %02h", phase, rdata, exp_rdata);
    end
    if (int'(active) != regb['h30][0]) begin
      fails++; $display("FAIL %s/R3 active got %0d exp %0d", phase, active, regb['h30][0]);
    end
    if (int'(host_hit) != exp_hit) begin
      fails++; $display("FAIL %s/R10 host_hit got %0d exp %0d", phase, host_hit, exp_hit);
    end
    if (int'(host_data) != exp_hdata) begin
      fails++; $display("FAIL %s/R11 host_data got %02h exp %02h", phase, host_data, exp_hdata);
    end
    wr_stb = 0; rd_stb = 0; dflt_pulse = 0; host_rd = 0;
  endtask

  task automatic wr(input int i, input int d);
    idx = 8'(i); wdata = 8'(d); wr_stb = 1; cyc();
  endtask
  task automatic rd(input int i);
    idx = 8'(i); rd_stb = 1; cyc();
  endtask
  task automatic probe(input int a);
    host_addr = 16'(a); host_rd = 1; cyc();
  endtask
  task automatic rd_all();
    rd('h30); rd('h31);
    for (int i = 'h60; i <= 'h75; i++) rd(i);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    model_defaults();
    repeat (3) cyc();
    rst = 0;
    phase = "R1"; rd_all();                      // power-up values
    phase = "R2";                                // writes locked out
    wr('h30, 1); wr('h60, 'h12); wr('h74, 1); rd('h30); rd('h60); rd('h74);
    cfg_en = 1;
    phase = "R5";
    wr('h60, 'h02); wr('h61, 'h20); wr('h66, 'h03); wr('h67, 'h30);
    wr('h6E, 'hFF); wr('h6F, 'hF8); rd_all();
    phase = "R6"; wr('h70, 'hFF); wr('h71, 'hFF); wr('h72, 'h5A); wr('h73, 'h02); rd_all();
    phase = "R7"; wr('h74, 'hFF); wr('h75, 'h01); rd('h74); rd('h75);
    phase = "R8"; wr('h20, 'h45); wr('h76, 'hFF); wr('h00, 'h77); wr('h32, 'hFF);
    rd('h20); rd('h76); rd('h00); rd('h32); rd('h5F); rd('hFF);
    phase = "R4"; wr('h31, 'hFF); rd('h31);
    phase = "R10";
    probe('h0220); probe('h0227); probe('h0228); probe('h021F);
    probe('h0333); probe('hFFFF); probe('hFFF7);
    phase = "R11"; probe('h0000); probe('h0100); cyc();
    phase = "R10"; wr('h31, 'h02); probe('h0224); probe('h0335);
    phase = "R3"; wr('h30, 'h03); rd('h30); rd('h31);
    phase = "R11"; probe('h0224); wr('h31, 'h03); probe('h0224);
    phase = "R3"; wr('h30, 0); probe('h0224);
    phase = "R9";
    idx = 8'h62; wdata = 8'hC3; wr_stb = 1; rd_stb = 1; cyc(); rd('h62); cyc(); cyc();
    phase = "R1";
    wr('h30, 1);
    idx = 8'h61; wdata = 8'h99; wr_stb = 1; dflt_pulse = 1; rd_stb = 1; cyc();
    rd_all();
    phase = "R1"; seed = 7;                      // mixed traffic
    for (int k = 0; k < 600; k++) begin
      int r, sel;
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      r = seed >>> 8;
      sel = r % 24;
      idx = (sel < 2) ? 8'(8'h30 + sel) : 8'(8'h5E + sel);
      wdata = 8'(r >>> 5);
      wr_stb = (r % 3) == 0;
      rd_stb = ((r >>> 3) % 2) == 0;
      host_rd = ((r >>> 4) % 2) == 0;
      host_addr = ((r >>> 6) % 2) ? 16'({regb[idx & 8'hFE], regb[idx | 8'h01]} + (r % 10))
                                  : 16'(r >>> 7);
      cfg_en = ((r >>> 9) % 8) != 0;
      dflt_pulse = ((r >>> 10) % 64) == 0;
      cyc();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule